// File: doc/BRIEF.md
# Banked Condition-Flag Store with Interrupt Context Switching

This block keeps the carry, zero and sign condition flags of a small processor core. Instead of saving flags to memory on an interrupt, it holds a separate flag set for normal execution and one for every interrupt priority level. Only one set is visible at a time. The ALU writes new flag values into the visible set through a write strobe. When the core takes an interrupt, it signals entry together with the level, and that level's own set becomes visible. When the core returns from the interrupt, the set of the interrupted context comes back.

An internal context stack records which context each accepted entry interrupted, so nested interrupts unwind in the right order. Sets are never cleared on a switch. A level therefore sees, on its next entry, the flags it left behind on its last exit. Subroutine call and return are ordinary execution and do not involve this block at all. Illegal sequences raise a one-cycle error pulse and leave the context unchanged: entering the level that is already running, returning with nothing to return to, entering when the stack is full, or requesting entry and return in the same cycle.

Top module: `irq_flag_banks`

## Requirements
- R1: After synchronous reset, every flag set is zero, normal mode is the visible context, the context stack is empty, `flags_rd` reads 0x00 and `seq_err` is low.
- R2: `flags_rd` packs the visible set with carry at bit 0, zero at bit 1 and sign at bit 2, and bits 7..3 read zero. `flag_c`, `flag_z` and `flag_s` carry the same three values.
- R3: When `flag_we` is high at a clock edge, `flag_in` (bit 0 carry, bit 1 zero, bit 2 sign) is stored into the set that was visible before that edge. It can be read from the next cycle.
- R4: An accepted `irq_enter` with `irq_level` = L makes level L's set visible from the next cycle. A flag write in the same cycle goes to the set being left.
- R5: An accepted `irq_return` makes the set of the interrupted context visible from the next cycle. After the outermost return, the normal-mode set is visible again.
- R6: Flag sets are not cleared on context switches. Re-entering level L shows exactly the values level L held when it last exited.
- R7: `irq_enter` naming the level that is already visible is rejected. `seq_err` is high for one cycle after the edge, and the visible set and the stack are unchanged.
- R8: `irq_return` while the context stack is empty (normal mode) is rejected with a one-cycle `seq_err`, and the visible set is unchanged.
- R9: The context stack holds CTX_DEPTH interrupted contexts (default 8). An entry while it is full is rejected with a one-cycle `seq_err`, and nothing is pushed.
- R10: `irq_enter` and `irq_return` together in one cycle are rejected with a one-cycle `seq_err` and no context change. A flag write in that cycle still goes to the visible set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_we | input | 1 | Write strobe for ALU flag update |
| flag_in | input | 3 | New flags: bit0 carry, bit1 zero, bit2 sign |
| irq_enter | input | 1 | Interrupt entry request |
| irq_level | input | $clog2(NUM_LEVELS) | Priority level being entered |
| irq_return | input | 1 | Return from interrupt |
| flag_c | output | 1 | Visible carry flag |
| flag_z | output | 1 | Visible zero flag |
| flag_s | output | 1 | Visible sign flag |
| flags_rd | output | 8 | Packed read value of the visible set |
| seq_err | output | 1 | One-cycle pulse after a rejected entry or return |

## Verification
The assertions assume that `irq_level` is stable and meaningful whenever `irq_enter` is high, and that entry and return are single-cycle strobes sampled at the clock edge. They do not assume that the core ever avoids an illegal sequence. Random stimulus therefore keeps every level within range but deliberately mixes in re-entries of the active level, returns from normal mode, simultaneous entry and return, and runs of entries long enough to fill the context stack, so that every rejection path is reached.

// File: rtl/flagbank_pkg.sv
package flagbank_pkg;

    // Bit positions of this struct match the packed read: sign[2] zero[1] carry[0]
    typedef struct packed {
        logic sgn;
        logic zro;
        logic cry;
    } flagset_t;

    localparam int FLAG_W  = 3;
    localparam int PACKED_W = 8;

    function automatic logic [PACKED_W-1:0] pack_flags(input flagset_t f);
        return {{(PACKED_W-FLAG_W){1'b0}}, f.sgn, f.zro, f.cry};
    endfunction

endpackage

// File: rtl/flag_bank_file.sv
module flag_bank_file
    import flagbank_pkg::*;
#(
    parameter int NBANKS = 9,
    localparam int IDX_W = $clog2(NBANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  flagset_t         wdata,
    input  logic [IDX_W-1:0] raddr,
    output flagset_t         rdata
);

    flagset_t bank_q [NBANKS];

    generate
        for (genvar b = 0; b < NBANKS; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank_q[b] <= '0;
                end else if (we && (waddr == IDX_W'(b))) begin
                    bank_q[b] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (raddr == IDX_W'(b)) rdata = bank_q[b];
        end
    end

endmodule

// File: rtl/ctx_stack.sv
module ctx_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]     mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] top_idx;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign wr_idx  = PTR_W'(cnt_q);
    assign top_idx = PTR_W'(cnt_q - 1'b1);
    assign top     = mem_q[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push && !full) begin
            mem_q[wr_idx] <= din;
            cnt_q         <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The controller must never push into a full stack (R9)
    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    // The controller must never pop an empty stack (R8)
    assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

endmodule

// File: rtl/irq_flag_banks.sv
module irq_flag_banks
    import flagbank_pkg::*;
#(
    parameter int NUM_LEVELS = 8,
    parameter int CTX_DEPTH  = 8,
    localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_we,
    input  logic [2:0]       flag_in,
    input  logic             irq_enter,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             irq_return,
    output logic             flag_c,
    output logic             flag_z,
    output logic             flag_s,
    output logic [7:0]       flags_rd,
    output logic             seq_err
);

    // Bank 0 is normal mode; bank L+1 belongs to interrupt level L
    localparam int NBANKS = NUM_LEVELS + 1;
    localparam int IDX_W  = $clog2(NBANKS);
    localparam logic [IDX_W-1:0] NORMAL_IDX = '0;

    logic [IDX_W-1:0] active_q;
    logic [IDX_W-1:0] lvl_bank;
    logic [IDX_W-1:0] stk_top;
    logic             stk_empty;
    logic             stk_full;
    logic             enter_ok;
    logic             ret_ok;
    logic             reject;
    flagset_t         vis_flags;

    assign lvl_bank = IDX_W'(irq_level) + IDX_W'(1);

    assign enter_ok = irq_enter && !irq_return && (lvl_bank != active_q) && !stk_full;
    assign ret_ok   = irq_return && !irq_enter && !stk_empty;
    assign reject   = (irq_enter || irq_return) && !enter_ok && !ret_ok;

    flag_bank_file #(
        .NBANKS (NBANKS)
    ) u_banks (
        .clk   (clk),
        .rst   (rst),
        .we    (flag_we),
        .waddr (active_q),
        .wdata (flagset_t'(flag_in)),
        .raddr (active_q),
        .rdata (vis_flags)
    );

    ctx_stack #(
        .DEPTH (CTX_DEPTH),
        .W     (IDX_W)
    ) u_ctx (
        .clk   (clk),
        .rst   (rst),
        .push  (enter_ok),
        .pop   (ret_ok),
        .din   (active_q),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= NORMAL_IDX;
            seq_err  <= 1'b0;
        end else begin
            seq_err <= reject;
            if (enter_ok) begin
                active_q <= lvl_bank;
            end else if (ret_ok) begin
                active_q <= stk_top;
            end
        end
    end

    assign flag_c   = vis_flags.cry;
    assign flag_z   = vis_flags.zro;
    assign flag_s   = vis_flags.sgn;
    assign flags_rd = pack_flags(vis_flags);

    // Return brings back the context recorded on the stack (R5)
    assert_ret_restores_R5: assert property (@(posedge clk) disable iff (rst)
        ret_ok |=> (active_q == $past(stk_top)));

    // Re-entering the running level is flagged and changes nothing (R7)
    assert_reenter_err_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_enter && !irq_return && (lvl_bank == active_q)) |=> (seq_err && $stable(active_q)));

    // Return from normal mode is flagged and changes nothing (R8)
    assert_empty_ret_err_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_return && !irq_enter && stk_empty) |=> (seq_err && $stable(active_q)));

    // Entry into a full stack is flagged and changes nothing (R9)
    assert_full_enter_err_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_enter && !irq_return && stk_full) |=> (seq_err && $stable(active_q)));

    // Simultaneous entry and return are flagged and change nothing (R10)
    assert_both_err_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_enter && irq_return) |=> (seq_err && $stable(active_q)));

endmodule

// File: tb/irq_flag_banks_test.sv
module irq_flag_banks_test;

    localparam int NL  = 8;
    localparam int DEP = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       flag_we;
    logic [2:0] flag_in;
    logic       irq_enter;
    logic [2:0] irq_level;
    logic       irq_return;
    logic       flag_c, flag_z, flag_s;
    logic [7:0] flags_rd;
    logic       seq_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state
    logic [2:0] m_bank [NL+1];
    int         m_act;
    int         m_stk [DEP];
    int         m_sp;
    logic       m_err;

    always #4 clk = ~clk;

    irq_flag_banks #(.NUM_LEVELS(NL), .CTX_DEPTH(DEP)) uut (
        .clk(clk), .rst(rst), .flag_we(flag_we), .flag_in(flag_in),
        .irq_enter(irq_enter), .irq_level(irq_level), .irq_return(irq_return),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s),
        .flags_rd(flags_rd), .seq_err(seq_err)
    );

    function automatic logic [7:0] exp_rd();
        return {5'b0, m_bank[m_act]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i <= NL; i++) m_bank[i] = 3'b000;
        m_act = 0; m_sp = 0; m_err = 1'b0;
    endtask

    task automatic model_step(input bit we, input logic [2:0] fin,
                              input bit en, input int lvl, input bit ret);
        m_err = 1'b0;
        if (we) m_bank[m_act] = fin;
        if (en && !ret) begin
            if ((lvl + 1 == m_act) || (m_sp == DEP)) m_err = 1'b1;
            else begin m_stk[m_sp] = m_act; m_sp++; m_act = lvl + 1; end
        end else if (ret && !en) begin
            if (m_sp == 0) m_err = 1'b1;
            else begin m_sp--; m_act = m_stk[m_sp]; end
        end else if (en && ret) begin
            m_err = 1'b1;
        end
    endtask

    task automatic check_out(input string tag);
        checks++;
        if (flags_rd !== exp_rd() || seq_err !== m_err) begin
            errors++;
            $display("FAIL %s flags_rd=%h seq_err=%b expected flags_rd=%h seq_err=%b",
                     tag, flags_rd, seq_err, exp_rd(), m_err);
        end
        checks++;
        if ({flag_s, flag_z, flag_c} !== flags_rd[2:0]) begin
            errors++;
            $display("FAIL R2 bits=%b expected %b", {flag_s, flag_z, flag_c}, flags_rd[2:0]);
        end
    endtask

    task automatic cycle(input bit we, input logic [2:0] fin, input bit en,
                         input int lvl, input bit ret, input string tag);
        @(negedge clk);
        flag_we = we; flag_in = fin; irq_enter = en;
        irq_level = 3'(lvl); irq_return = ret;
        @(posedge clk);
        model_step(we, fin, en, lvl, ret);
        #2;
        check_out(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_f1a6));
        rst = 1'b1; flag_we = 0; flag_in = 0; irq_enter = 0; irq_level = 0; irq_return = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 check_out("R1 reset state");

        // R3: write in normal mode
        cycle(1, 3'b101, 0, 0, 0, "R3 normal write");
        // R4: enter level 2 with same-cycle write going to normal set
        cycle(1, 3'b011, 1, 2, 0, "R4 enter level 2");
        cycle(1, 3'b110, 0, 0, 0, "R3 write level 2");
        // R5: return restores normal
        cycle(0, 3'b000, 0, 0, 1, "R5 return to normal");
        // R6: level 2 kept its values
        cycle(0, 3'b000, 1, 2, 0, "R6 re-enter level 2 persists");
        // R7: re-entry of active level
        cycle(0, 3'b000, 1, 2, 0, "R7 re-enter active level");
        cycle(0, 3'b000, 0, 0, 0, "R7 error pulse ends");
        // nested entry then unwind
        cycle(1, 3'b111, 1, 5, 0, "R4 nested enter level 5");
        cycle(0, 3'b000, 0, 0, 1, "R5 return to level 2");
        cycle(0, 3'b000, 0, 0, 1, "R5 return to normal");
        // R8: return with empty stack
        cycle(0, 3'b000, 0, 0, 1, "R8 empty return");
        // R10: both at once, write still applies
        cycle(1, 3'b010, 1, 4, 1, "R10 enter and return together");
        // R9: fill the stack
        for (int l = 0; l < NL; l++) cycle(1, 3'(l), 1, l, 0, "R9 fill stack");
        cycle(0, 3'b000, 1, 0, 0, "R9 enter while full");
        for (int l = 0; l < NL; l++) cycle(0, 3'b000, 0, 0, 1, "R5 unwind");
        cycle(0, 3'b000, 0, 0, 0, "R5 normal after unwind");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit en, ret;
            r   = $urandom_range(0, 99);
            en  = (r < 25) || (r >= 95);
            ret = (r >= 25 && r < 45) || (r >= 95);
            cycle($urandom_range(0, 1), 3'($urandom), en, $urandom_range(0, NL-1), ret,
                  "R3/R4/R5/R6 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule